// File: doc/BRIEF.md
# Dual Wiper Register Command Executor

This block sits behind a two-wire serial slave front end and carries out register commands for two digital potentiometers. Each potentiometer owns a volatile wiper register of `TAP_BITS` bits and four data registers of the same width that stand in for non-volatile storage. The front end tells the block when its slave address has matched, hands over each received byte with a one-cycle strobe, and signals STOP. The block decodes the instruction byte, updates wiper and data registers, returns a read byte with a strobe, and drives both wiper values continuously.

Changes to data registers are held pending until STOP. They are then committed, and `busy` stays high for `WRITE_CYCLES` clock cycles to model the storage write time. While `busy` is high, a new address is refused and the rest of that frame is ignored. An increment/decrement mode moves the selected wiper one tap per step strobe. After reset, each wiper is reloaded from data register 0 of its potentiometer.

Top module: `pot_cmd_exec`

## Requirements
- R1: Reset clears `busy` and `rd_valid`. On the first clock after reset is released, each wiper takes the value of data register 0 of its own potentiometer.
- R2: Instruction byte fields are opcode in bits [7:4], potentiometer select in bit 2 and data-register select in bits [1:0]. Bit 3 is not used. Opcode 1010 followed by a data byte loads the low `TAP_BITS` bits of that byte into the selected wiper on the clock edge that receives the byte. The upper bits of the byte are ignored.
- R3: Opcode 1001 reads the selected wiper and opcode 1011 reads the selected data register. `rd_valid` pulses for one cycle on the clock edge that receives the instruction byte. `rd_data` carries the value, zero-extended to 8 bits.
- R4: Opcode 1100 followed by a data byte writes the selected data register. The write takes effect only at STOP. A new address that arrives before STOP discards it.
- R5: Opcode 1101 copies the selected data register into the wiper of the same potentiometer on the instruction-byte edge, and `busy` does not rise.
- R6: Opcode 1110 captures the selected wiper at the instruction byte and stores it into the selected data register of that potentiometer at STOP.
- R7: Opcode 0001 copies data register [1:0] of each potentiometer into its own wiper. Opcode 1000 stores each wiper into its own data register [1:0] at STOP. Both act on the two potentiometers in the same cycle.
- R8: A STOP that commits a pending data-register write raises `busy` for exactly `WRITE_CYCLES` cycles. An address that arrives while `busy` is high is refused, and the bytes that follow in that frame change nothing.
- R9: Opcode 0010 enters step mode for the selected potentiometer. Each `step_valid` moves its wiper up by one when `step_up` is 1 and down by one when it is 0. The wiper saturates at all-ones and at zero. Step mode ends at STOP or at a new address.
- R10: Unused opcodes change no register. Bytes that arrive after a command is complete, and before the next address, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_req | input | 1 | Pulse: the slave address matched, and a new frame begins |
| rx_valid | input | 1 | Pulse: `rx_byte` holds a received byte |
| rx_byte | input | 8 | Received instruction or data byte |
| stop | input | 1 | Pulse: a STOP condition was seen |
| step_valid | input | 1 | Pulse: one step in step mode |
| step_up | input | 1 | Step direction: 1 up, 0 down |
| rd_valid | output | 1 | Pulse: `rd_data` holds read data |
| rd_data | output | 8 | Read data, upper bits zero |
| busy | output | 1 | A data-register write is in progress, and addresses are refused |
| wiper0 | output | TAP_BITS | Wiper value of potentiometer 0 |
| wiper1 | output | TAP_BITS | Wiper value of potentiometer 1 |

## Verification
Two situations are hard to reach from the ports. One is an address that lands inside the counted write window. The other is a repeated address that arrives between a data-register write and its STOP. To reach the first, the stimulus issues a STOP that commits a write and then, while `busy` is still high, sends a full wiper-write frame; it checks that neither wiper moved. To reach the second, it sends a data-register write, restarts with a new address instead of STOP, and reads the register back to show that the old value survived and that `busy` never rose. A behavioural model follows every clock, so wipers, `busy` and read data are compared on each cycle as well.

// File: rtl/pot_cmd_exec.sv
module pot_cmd_exec #(
  parameter int TAP_BITS     = 6,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_req,
  input  logic                rx_valid,
  input  logic [7:0]          rx_byte,
  input  logic                stop,
  input  logic                step_valid,
  input  logic                step_up,
  output logic                rd_valid,
  output logic [7:0]          rd_data,
  output logic                busy,
  output logic [TAP_BITS-1:0] wiper0,
  output logic [TAP_BITS-1:0] wiper1
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);
  localparam logic [TAP_BITS-1:0] TOP = '1;

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_DATA, S_STEP, S_DONE} st_t;

  st_t                st;
  logic [TAP_BITS-1:0] dr [2][4];
  logic [TAP_BITS-1:0] wp [2];
  logic [TAP_BITS-1:0] pend_val [2];
  logic [1:0]          pend_en, pend_idx, reg_q;
  logic [3:0]          op_q;
  logic                pot_q, recall;
  logic [CW-1:0]       cnt;

  wire [3:0]          op   = rx_byte[7:4];
  wire                psel = rx_byte[2];
  wire [1:0]          rsel = rx_byte[1:0];
  wire [TAP_BITS-1:0] din  = rx_byte[TAP_BITS-1:0];

  assign busy   = (cnt != '0);
  assign wiper0 = wp[0];
  assign wiper1 = wp[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      wp[0]    <= '0;
      wp[1]    <= '0;
      pend_en  <= '0;
      pend_idx <= '0;
      pend_val[0] <= '0;
      pend_val[1] <= '0;
      op_q     <= '0;
      pot_q    <= 1'b0;
      reg_q    <= '0;
      cnt      <= '0;
      recall   <= 1'b1;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      recall   <= 1'b0;
      if (recall) begin
        wp[0] <= dr[0][0];
        wp[1] <= dr[1][0];
      end
      if (busy) cnt <= cnt - 1'b1;
      if (stop) begin
        st <= S_IDLE;
        if (pend_en != '0) begin
          cnt     <= CW'(WRITE_CYCLES);
          pend_en <= '0;
        end
      end else if (addr_req) begin
        st      <= busy ? S_IDLE : S_CMD;
        pend_en <= '0;
      end else begin
        case (st)
          S_CMD: if (rx_valid) begin
            op_q  <= op;
            pot_q <= psel;
            reg_q <= rsel;
            st    <= S_DONE;
            case (op)
              4'b1001: begin rd_valid <= 1'b1; rd_data <= 8'(wp[psel]); end
              4'b1011: begin rd_valid <= 1'b1; rd_data <= 8'(dr[psel][rsel]); end
              4'b1010, 4'b1100: st <= S_DATA;
              4'b1101: wp[psel] <= dr[psel][rsel];
              4'b1110: begin
                pend_en        <= psel ? 2'b10 : 2'b01;
                pend_idx       <= rsel;
                pend_val[psel] <= wp[psel];
              end
              4'b0001: begin
                wp[0] <= dr[0][rsel];
                wp[1] <= dr[1][rsel];
              end
              4'b1000: begin
                pend_en     <= 2'b11;
                pend_idx    <= rsel;
                pend_val[0] <= wp[0];
                pend_val[1] <= wp[1];
              end
              4'b0010: st <= S_STEP;
              default: ;
            endcase
          end
          S_DATA: if (rx_valid) begin
            st <= S_DONE;
            if (op_q == 4'b1010) wp[pot_q] <= din;
            else begin
              pend_en         <= pot_q ? 2'b10 : 2'b01;
              pend_idx        <= reg_q;
              pend_val[pot_q] <= din;
            end
          end
          S_STEP: if (step_valid) begin
            if (step_up && wp[pot_q] != TOP) wp[pot_q] <= wp[pot_q] + 1'b1;
            else if (!step_up && wp[pot_q] != '0) wp[pot_q] <= wp[pot_q] - 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && stop) begin
      for (int p = 0; p < 2; p++)
        if (pend_en[p]) dr[p][pend_idx] <= pend_val[p];
    end
  end

  assert_busy_from_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop));

  assert_refused_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && $past(addr_req) && !$past(stop)) |-> (st == S_IDLE));

  assert_read_follows_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rx_valid));

  assert_wiper0_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper0 != $past(wiper0)) |-> $past(rx_valid || step_valid || recall));

  assert_wiper1_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wiper1 != $past(wiper1)) |-> $past(rx_valid || step_valid || recall));

  assert_step_unit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_STEP && !$past(rx_valid) && !$past(recall))
      |-> (TAP_BITS'(wiper0 - $past(wiper0) + 1'b1) <= 2 &&
           TAP_BITS'(wiper1 - $past(wiper1) + 1'b1) <= 2));

  for (genvar gp = 0; gp < 2; gp++) begin : g_nv
    for (genvar gr = 0; gr < 4; gr++) begin : g_r
      assert_store_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dr[gp][gr]) |-> $past(stop));
    end
  end
endmodule

// File: tb/sim_pot_cmd_exec.sv
module sim_pot_cmd_exec;
  localparam int TB = 6;
  localparam int W  = 12;

  logic clk = 0, rst_n = 0;
  logic addr_req = 0, rx_valid = 0, stop = 0, step_valid = 0, step_up = 0;
  logic [7:0] rx_byte = 0;
  logic rd_valid, busy;
  logic [7:0] rd_data;
  logic [TB-1:0] wiper0, wiper1;

  pot_cmd_exec #(.TAP_BITS(TB), .WRITE_CYCLES(W)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_req(addr_req), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .stop(stop), .step_valid(step_valid), .step_up(step_up),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .wiper0(wiper0), .wiper1(wiper1));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cycles = 0;
  string cur = "R1";
  bit known = 0;

  // behavioural reference
  int m_wp[2], m_dr[2][4], m_pv[2];
  int m_pend[2];
  int m_pidx, m_left, m_mode, m_op, m_pot, m_reg, m_rdd;
  bit m_rdv, m_recall;

  initial foreach (m_dr[p, r]) m_dr[p][r] = 0;

  always @(posedge clk) begin
    int o_wp[2];
    int b, lim;
    o_wp = m_wp;
    lim = (1 << TB) - 1;
    b = rx_byte;
    if (!rst_n) begin
      m_wp = '{0, 0}; m_pend = '{0, 0}; m_left = 0; m_mode = 0;
      m_rdv = 0; m_rdd = 0; m_recall = 1;
    end else begin
      m_rdv = 0;
      if (m_recall) begin m_wp[0] = m_dr[0][0]; m_wp[1] = m_dr[1][0]; end
      m_recall = 0;
      if (m_left > 0) m_left--;
      if (stop) begin
        if (m_pend[0] || m_pend[1]) begin
          for (int p = 0; p < 2; p++) if (m_pend[p]) m_dr[p][m_pidx] = m_pv[p];
          m_left = W;
        end
        m_pend = '{0, 0};
        m_mode = 0;
      end else if (addr_req) begin
        m_mode = (m_left > 0 || busy) ? 0 : 1;
        m_pend = '{0, 0};
      end else if (m_mode == 1 && rx_valid) begin
        m_op = b / 16; m_pot = (b / 4) % 2; m_reg = b % 4; m_mode = 4;
        if (m_op == 9) begin m_rdv = 1; m_rdd = o_wp[m_pot]; end
        else if (m_op == 11) begin m_rdv = 1; m_rdd = m_dr[m_pot][m_reg]; end
        else if (m_op == 10 || m_op == 12) m_mode = 2;
        else if (m_op == 13) m_wp[m_pot] = m_dr[m_pot][m_reg];
        else if (m_op == 14) begin m_pend[m_pot] = 1; m_pidx = m_reg; m_pv[m_pot] = o_wp[m_pot]; end
        else if (m_op == 1) begin m_wp[0] = m_dr[0][m_reg]; m_wp[1] = m_dr[1][m_reg]; end
        else if (m_op == 8) begin m_pend = '{1, 1}; m_pidx = m_reg; m_pv = o_wp; end
        else if (m_op == 2) m_mode = 3;
      end else if (m_mode == 2 && rx_valid) begin
        m_mode = 4;
        if (m_op == 10) m_wp[m_pot] = b % (lim + 1);
        else begin m_pend[m_pot] = 1; m_pidx = m_reg; m_pv[m_pot] = b % (lim + 1); end
      end else if (m_mode == 3 && step_valid) begin
        if (step_up && m_wp[m_pot] < lim) m_wp[m_pot]++;
        else if (!step_up && m_wp[m_pot] > 0) m_wp[m_pot]--;
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(cur, busy, m_left > 0);
      chk(cur, rd_valid, m_rdv);
      if (m_rdv) chk(cur, rd_data, m_rdd);
      if (known) begin
        chk(cur, wiper0, m_wp[0]);
        chk(cur, wiper1, m_wp[1]);
      end
    end
  end

  task automatic tick(int n = 1); repeat (n) @(negedge clk); endtask
  task automatic addr(); addr_req = 1; tick(); addr_req = 0; endtask
  task automatic stp(); stop = 1; tick(); stop = 0; endtask
  task automatic send(int v); rx_byte = 8'(v); rx_valid = 1; tick(); rx_valid = 0; endtask
  task automatic step(bit up); step_up = up; step_valid = 1; tick(); step_valid = 0; endtask
  task automatic wait_idle(); while (busy) tick(); tick(); endtask
  task automatic wr_dr(int p, int r, int v);
    addr(); send(8'hC0 | (p << 2) | r); send(v); stp(); wait_idle();
  endtask
  task automatic rd(int cmd, output int v);
    addr(); send(cmd); v = rd_data; chk(cur, rd_valid, 1); stp(); tick();
  endtask

  initial begin
    int v, n;
    tick(3);
    rst_n = 1; tick();
    chk("R1", busy, 0); chk("R1", rd_valid, 0);
    for (int p = 0; p < 2; p++)
      for (int r = 0; r < 4; r++) wr_dr(p, r, 5 + 9 * p + 13 * r);
    rst_n = 0; tick(2); rst_n = 1; tick(2);
    known = 1;
    chk("R1", wiper0, 5); chk("R1", wiper1, 14);

    cur = "R2";
    addr(); send(8'hA4); send(8'hFF); stp(); tick();
    chk("R2", wiper1, 63);
    addr(); send(8'hA8); send(8'h15); stp(); tick();
    chk("R2", wiper0, 21);

    cur = "R3";
    rd(8'h94, v); chk("R3", v, 63);
    rd(8'hB2, v); chk("R3", v, 31);
    rd(8'hB7, v); chk("R3", v, 53);

    cur = "R4";
    wr_dr(0, 3, 8'hEA); rd(8'hB3, v); chk("R4", v, 42);
    addr(); send(8'hC1); send(7); addr(); stp(); tick();
    chk("R4", busy, 0);
    rd(8'hB1, v); chk("R4", v, 18);

    cur = "R5";
    addr(); send(8'hD6); tick(); chk("R5", wiper1, 40); chk("R5", busy, 0);
    stp(); tick(); chk("R5", busy, 0);

    cur = "R6";
    addr(); send(8'hE2); stp();
    n = 0; while (busy) begin n++; tick(); end
    chk("R8", n, W);
    rd(8'hB2, v); chk("R6", v, 21);

    cur = "R7";
    addr(); send(8'h13); tick();
    chk("R7", wiper0, 42); chk("R7", wiper1, 53);
    stp(); tick();
    addr(); send(8'hA0); send(9); stp(); tick();
    addr(); send(8'h81); stp(); wait_idle();
    rd(8'hB1, v); chk("R7", v, 9);
    rd(8'hB5, v); chk("R7", v, 53);

    cur = "R8";
    addr(); send(8'h80); stp(); tick(2);
    addr(); send(8'hA0); send(1); send(8'h24); tick(); stp();
    chk("R8", wiper0, 9);
    wait_idle();

    cur = "R9";
    addr(); send(8'h24);
    for (int i = 0; i < 14; i++) step(1);
    chk("R9", wiper1, 63);
    step(0); chk("R9", wiper1, 62);
    stp(); step(0); chk("R9", wiper1, 62);
    addr(); send(8'h20);
    for (int i = 0; i < 12; i++) step(0);
    chk("R9", wiper0, 0);
    stp(); tick();

    cur = "R10";
    addr(); send(8'h54); send(8'hA4); send(3); stp(); tick();
    chk("R10", wiper1, 62); chk("R10", busy, 0);
    addr(); send(8'hF0); stp(); tick();
    chk("R10", wiper0, 0); chk("R10", busy, 0);
    tick(4);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule